// File: doc/BRIEF.md
# Operand Effective Address Resolver

This block turns the addressing mode and operand bytes of an 8-bit processor instruction into a 16-bit effective address. The mode, the two operand bytes and both index registers are presented with a one-cycle `start` pulse. Modes that locate their target directly finish in one cycle. Modes that go through a pointer read its two bytes, one at a time, over a byte-wide read port. That port returns data one cycle after the request. When the work is finished, a single-cycle `done` pulse presents the address, a result kind and the instruction length in bytes.

Each mode keeps its own wraparound behaviour. Zero-page arithmetic stays inside page zero, and full-address arithmetic wraps at 64 Ki. The pointer read for the indirect jump never crosses into the next page when the pointer's low byte is at the end of a page. For branch offsets the block returns the offset sign-extended to 16 bits, so that the program counter logic can add it directly.

Top module: `addr_mode_unit`

## Requirements
- R1: `mode` codes are 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page+X, 5 zero page+Y, 6 absolute, 7 absolute+X, 8 absolute+Y, 9 pre-indexed indirect (X), 10 post-indexed indirect (Y), 11 indirect jump, 12 relative, and 13 to 15 behave as implied. `ilen` is 1 for implied and accumulator, 2 for immediate, zero-page, relative and both indirect-indexed modes, and 3 for absolute, absolute indexed and indirect jump.
- R2: `kind` is 0 none (implied), 1 address, 2 immediate, 3 accumulator, 4 relative. `ea` is 0 for kinds none, immediate and accumulator.
- R3: Zero page gives {0x00, lo}. Zero page+X and zero page+Y give {0x00, (lo+index) mod 256}, so the high byte is always 0.
- R4: Absolute gives hi*256+lo. The indexed absolute forms add X or Y to that value modulo 65536.
- R5: Pre-indexed indirect forms p=(lo+X) mod 256. It reads the pointer low byte at {0x00,p} and the high byte at {0x00,(p+1) mod 256}. The result is the pointer.
- R6: Post-indexed indirect reads the pointer low byte at {0x00,lo} and the high byte at {0x00,(lo+1) mod 256}. The result is (pointer+Y) mod 65536.
- R7: Indirect jump reads the low byte at {hi,lo} and the high byte at {hi,(lo+1) mod 256}. The high byte of the pointer address is never incremented.
- R8: Relative mode gives `ea` = the low operand byte sign-extended to 16 bits.
- R9: `done` is a one-cycle pulse. It comes 1 cycle after an accepted `start` for modes without a pointer and 4 cycles after for the three pointer modes. A `start` is ignored while `busy` is high.
- R10: During and after reset, `done`, `busy` and `rd_req` are 0.
- R11: A pointer mode issues exactly two read requests, low byte first and then high byte. Every other mode issues none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving the presented operands |
| mode | input | 4 | Addressing mode code (R1) |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| x_idx | input | 8 | X index register |
| y_idx | input | 8 | Y index register |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Operation in progress, start ignored |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address or sign-extended offset |
| kind | output | 3 | Result kind (R2) |
| ilen | output | 2 | Instruction length in bytes |

## Verification
The hardest cases to reach are the page-boundary wraps of the pointer modes: a pointer at 0xFF in page zero, X pushing the zero-page sum past 0xFF, and an indirect-jump pointer whose low byte is 0xFF. Random operands reach these only rarely, so the stimulus sets each one up directly. The bench memory returns a byte that depends on both address bytes. A wrong carry into the high byte, or a read from the wrong page, therefore changes the resolved address, and the bench also records the two request addresses. A second `start` is pushed in while the block is busy, to show that it is ignored.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  typedef enum logic [3:0] {
    M_IMPL = 4'd0, M_ACC = 4'd1, M_IMM = 4'd2, M_ZP = 4'd3, M_ZPX = 4'd4,
    M_ZPY = 4'd5, M_ABS = 4'd6, M_ABSX = 4'd7, M_ABSY = 4'd8, M_INDX = 4'd9,
    M_INDY = 4'd10, M_JIND = 4'd11, M_REL = 4'd12
  } mode_e;

  typedef enum logic [2:0] {
    K_NONE = 3'd0, K_ADDR = 3'd1, K_IMM = 3'd2, K_ACC = 3'd3, K_REL = 3'd4
  } kind_e;

  // page-zero sum: carry out of the low byte is dropped
  function automatic logic [ADDR_W-1:0] zp_index(input logic [BYTE_W-1:0] base,
                                                 input logic [BYTE_W-1:0] idx);
    logic [BYTE_W-1:0] s;
    s = base + idx;
    return {{BYTE_W{1'b0}}, s};
  endfunction

  // full-width sum wrapping at 2**ADDR_W
  function automatic logic [ADDR_W-1:0] abs_index(input logic [BYTE_W-1:0] lo,
                                                  input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] idx);
    return {hi, lo} + {{BYTE_W{1'b0}}, idx};
  endfunction

  // next byte address inside the same page
  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] p);
    logic [BYTE_W-1:0] l;
    l = p[BYTE_W-1:0] + 1'b1;
    return {p[ADDR_W-1:BYTE_W], l};
  endfunction

  function automatic logic [ADDR_W-1:0] sext8(input logic [BYTE_W-1:0] b);
    return {{BYTE_W{b[BYTE_W-1]}}, b};
  endfunction
endpackage

// File: rtl/amu_decode.sv
module amu_decode
  import amu_pkg::*;
(
  input  logic [3:0]        mode,
  input  logic [BYTE_W-1:0] opnd_lo,
  input  logic [BYTE_W-1:0] opnd_hi,
  input  logic [BYTE_W-1:0] x_idx,
  input  logic [BYTE_W-1:0] y_idx,
  output logic [1:0]        ilen,
  output kind_e             kind,
  output logic              needs_ptr,
  output logic              zp_class,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic [BYTE_W-1:0] post_add,
  output logic [ADDR_W-1:0] direct_ea
);
  always_comb begin
    ilen      = 2'd1;
    kind      = K_NONE;
    needs_ptr = 1'b0;
    zp_class  = 1'b0;
    ptr_addr  = '0;
    post_add  = '0;
    direct_ea = '0;
    case (mode_e'(mode))
      M_ACC:  kind = K_ACC;
      M_IMM:  begin ilen = 2'd2; kind = K_IMM; end
      M_ZP:   begin ilen = 2'd2; kind = K_ADDR; zp_class = 1'b1;
                    direct_ea = zp_index(opnd_lo, '0); end
      M_ZPX:  begin ilen = 2'd2; kind = K_ADDR; zp_class = 1'b1;
                    direct_ea = zp_index(opnd_lo, x_idx); end
      M_ZPY:  begin ilen = 2'd2; kind = K_ADDR; zp_class = 1'b1;
                    direct_ea = zp_index(opnd_lo, y_idx); end
      M_ABS:  begin ilen = 2'd3; kind = K_ADDR;
                    direct_ea = abs_index(opnd_lo, opnd_hi, '0); end
      M_ABSX: begin ilen = 2'd3; kind = K_ADDR;
                    direct_ea = abs_index(opnd_lo, opnd_hi, x_idx); end
      M_ABSY: begin ilen = 2'd3; kind = K_ADDR;
                    direct_ea = abs_index(opnd_lo, opnd_hi, y_idx); end
      M_INDX: begin ilen = 2'd2; kind = K_ADDR; needs_ptr = 1'b1;
                    ptr_addr = zp_index(opnd_lo, x_idx); end
      M_INDY: begin ilen = 2'd2; kind = K_ADDR; needs_ptr = 1'b1;
                    ptr_addr = zp_index(opnd_lo, '0); post_add = y_idx; end
      M_JIND: begin ilen = 2'd3; kind = K_ADDR; needs_ptr = 1'b1;
                    ptr_addr = {opnd_hi, opnd_lo}; end
      M_REL:  begin ilen = 2'd2; kind = K_REL;
                    direct_ea = sext8(opnd_lo); end
      default: ;
    endcase
  end
endmodule

// File: rtl/amu_fetch.sv
module amu_fetch
  import amu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              needs_ptr,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic [BYTE_W-1:0] post_add,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] fetched_ea
);
  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_LAST, S_DONE} st_e;
  st_e state;
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) state <= needs_ptr ? S_LO : S_DONE;
        S_LO:   state <= S_HI;
        S_HI:   begin lo_q <= rd_data; state <= S_LAST; end
        S_LAST: begin hi_q <= rd_data; state <= S_DONE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req  = (state == S_LO) || (state == S_HI);
    rd_addr = '0;
    if (state == S_LO) rd_addr = ptr_addr;
    else if (state == S_HI) rd_addr = page_next(ptr_addr);
  end

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);
  assign fetched_ea = abs_index(lo_q, hi_q, post_add);

  // R9: result strobe lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: no read traffic while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
  // R7: high pointer byte is read from the same page, low byte plus one
  a_r7_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && state == S_LO) |=>
      (rd_req && rd_addr == {$past(rd_addr[ADDR_W-1:BYTE_W]), $past(rd_addr[BYTE_W-1:0]) + 8'd1}));
endmodule

// File: rtl/addr_mode_unit.sv
module addr_mode_unit
  import amu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [BYTE_W-1:0] opnd_lo,
  input  logic [BYTE_W-1:0] opnd_hi,
  input  logic [BYTE_W-1:0] x_idx,
  input  logic [BYTE_W-1:0] y_idx,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [2:0]        kind,
  output logic [1:0]        ilen
);
  logic [1:0]        d_len;
  kind_e             d_kind;
  logic              d_needs, d_zp;
  logic [ADDR_W-1:0] d_ptr, d_direct;
  logic [BYTE_W-1:0] d_post;

  logic [1:0]        q_len;
  kind_e             q_kind;
  logic              q_needs, q_zp;
  logic [ADDR_W-1:0] q_ptr, q_direct;
  logic [BYTE_W-1:0] q_post;

  logic              accept;
  logic [ADDR_W-1:0] fetched_ea;

  amu_decode u_dec (
    .mode(mode), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .x_idx(x_idx), .y_idx(y_idx),
    .ilen(d_len), .kind(d_kind), .needs_ptr(d_needs), .zp_class(d_zp),
    .ptr_addr(d_ptr), .post_add(d_post), .direct_ea(d_direct)
  );

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_len <= 2'd0; q_kind <= K_NONE; q_needs <= 1'b0; q_zp <= 1'b0;
      q_ptr <= '0; q_post <= '0; q_direct <= '0;
    end else if (accept) begin
      q_len <= d_len; q_kind <= d_kind; q_needs <= d_needs; q_zp <= d_zp;
      q_ptr <= d_ptr; q_post <= d_post; q_direct <= d_direct;
    end
  end

  amu_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .accept(accept), .needs_ptr(d_needs),
    .ptr_addr(q_ptr), .post_add(q_post), .rd_data(rd_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .busy(busy), .done(done),
    .fetched_ea(fetched_ea)
  );

  assign ea   = q_needs ? fetched_ea : q_direct;
  assign kind = q_kind;
  assign ilen = q_len;

  // R1: a finished result always carries a length of 1 to 3
  a_r1_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ilen != 2'd0));
  // R8: relative offsets arrive sign-extended
  a_r8_rel_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_REL) |-> (ea[ADDR_W-1:BYTE_W] == {BYTE_W{ea[BYTE_W-1]}}));
  // R3: page-zero modes never leave page zero
  a_r3_zp_page: assert property (@(posedge clk) disable iff (!rst_n)
    (done && q_zp) |-> (ea[ADDR_W-1:BYTE_W] == '0));
  // R11: direct modes finish without touching memory
  a_r11_direct_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !q_needs) |-> !$past(rd_req));
endmodule

// File: tb/addr_mode_unit_tb.sv
`timescale 1ns/1ps
module addr_mode_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [7:0] opnd_lo = '0, opnd_hi = '0, x_idx = '0, y_idx = '0;
  logic rd_req;
  logic [15:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic busy, done;
  logic [15:0] ea;
  logic [2:0] kind;
  logic [1:0] ilen;

  int checks = 0;
  int fails = 0;
  int nreq = 0;
  logic [15:0] req_a0 = '0, req_a1 = '0;

  always #2.5 clk = ~clk;

  addr_mode_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd_lo(opnd_lo),
    .opnd_hi(opnd_hi), .x_idx(x_idx), .y_idx(y_idx), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .ea(ea), .kind(kind), .ilen(ilen)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (rd_req) begin
      rd_data <= memf(rd_addr);
      if (nreq == 0) req_a0 <= rd_addr;
      if (nreq == 1) req_a1 <= rd_addr;
      nreq <= nreq + 1;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_of(input logic [3:0] m, input logic [7:0] a, b, xx, yy,
                           output logic [15:0] e, output logic [2:0] k,
                           output logic [1:0] l, output int reads);
    logic [7:0] p, lo, hi;
    e = 16'h0; k = 3'd0; l = 2'd1; reads = 0;
    case (m)
      4'd1: k = 3'd3;
      4'd2: begin k = 3'd2; l = 2'd2; end
      4'd3: begin k = 3'd1; l = 2'd2; e = {8'h00, a}; end
      4'd4: begin k = 3'd1; l = 2'd2; p = a + xx; e = {8'h00, p}; end
      4'd5: begin k = 3'd1; l = 2'd2; p = a + yy; e = {8'h00, p}; end
      4'd6: begin k = 3'd1; l = 2'd3; e = {b, a}; end
      4'd7: begin k = 3'd1; l = 2'd3; e = 16'({b, a} + 17'(xx)); end
      4'd8: begin k = 3'd1; l = 2'd3; e = 16'({b, a} + 17'(yy)); end
      4'd9: begin k = 3'd1; l = 2'd2; reads = 2; p = a + xx;
              lo = memf({8'h00, p}); p = p + 8'd1; hi = memf({8'h00, p}); e = {hi, lo}; end
      4'd10: begin k = 3'd1; l = 2'd2; reads = 2; p = a;
              lo = memf({8'h00, p}); p = p + 8'd1; hi = memf({8'h00, p});
              e = 16'({hi, lo} + 17'(yy)); end
      4'd11: begin k = 3'd1; l = 2'd3; reads = 2; p = a;
              lo = memf({b, p}); p = p + 8'd1; hi = memf({b, p}); e = {hi, lo}; end
      4'd12: begin k = 3'd4; l = 2'd2; e = {{8{a[7]}}, a}; end
      default: ;
    endcase
  endtask

  // poke: hold start high into the busy period with different operands (R9)
  task automatic run_op(input logic [3:0] m, input logic [7:0] a, b, xx, yy, input bit poke);
    logic [15:0] e; logic [2:0] k; logic [1:0] l; int reads; int lat;
    expect_of(m, a, b, xx, yy, e, k, l, reads);
    @(negedge clk);
    mode = m; opnd_lo = a; opnd_hi = b; x_idx = xx; y_idx = yy; start = 1'b1; nreq = 0;
    @(negedge clk);
    lat = 1;
    if (poke) begin mode = 4'd6; opnd_lo = ~a; opnd_hi = ~b; start = 1'b1; end
    else start = 1'b0;
    while (!done && lat < 12) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    if (lat >= 12) begin
      checks++; fails++;
      $display("FAIL R9 watchdog: no done for mode %0d actual=timeout expected=done", m);
    end else begin
      chk($sformatf("R3 R4 R5 R6 R7 R8 ea mode=%0d", m), ea, e);
      chk($sformatf("R2 kind mode=%0d", m), 16'(kind), 16'(k));
      chk($sformatf("R1 ilen mode=%0d", m), 16'(ilen), 16'(l));
      chk($sformatf("R9 latency mode=%0d", m), 16'(lat), (reads == 2) ? 16'd4 : 16'd1);
      chk($sformatf("R11 read count mode=%0d", m), 16'(nreq), 16'(reads));
    end
    @(negedge clk);
    start = 1'b0;
    chk("R9 done single pulse", 16'(done), 16'd0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 done in reset", 16'(done), 16'd0);
    chk("R10 busy in reset", 16'(busy), 16'd0);
    chk("R10 rd_req in reset", 16'(rd_req), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 done after reset", 16'(done), 16'd0);

    // directed corners
    run_op(4'd4, 8'hF0, 8'h77, 8'h20, 8'h00, 1'b0);   // R3 zp+X wraps to 0x0010
    run_op(4'd5, 8'hFF, 8'h77, 8'h00, 8'h01, 1'b0);   // R3 zp+Y wraps to 0x0000
    run_op(4'd7, 8'hF0, 8'hFF, 8'h20, 8'h00, 1'b0);   // R4 abs+X wraps to 0x0010
    run_op(4'd8, 8'h34, 8'h12, 8'h00, 8'hFF, 1'b0);   // R4 abs+Y page cross
    run_op(4'd9, 8'h80, 8'h55, 8'h7F, 8'h00, 1'b0);   // R5 pointer at 0xFF
    chk("R5 low byte address", req_a0, 16'h00FF);
    chk("R5 high byte wraps in page zero", req_a1, 16'h0000);
    run_op(4'd10, 8'hFF, 8'h55, 8'h00, 8'hC3, 1'b0);  // R6 pointer straddles 0xFF
    chk("R6 high byte wraps in page zero", req_a1, 16'h0000);
    run_op(4'd11, 8'hFF, 8'h12, 8'h00, 8'h00, 1'b0);  // R7 page-end pointer
    chk("R7 low byte address", req_a0, 16'h12FF);
    chk("R7 high byte stays in page", req_a1, 16'h1200);
    run_op(4'd12, 8'h80, 8'h00, 8'h00, 8'h00, 1'b0);  // R8 most negative
    run_op(4'd12, 8'h7F, 8'h00, 8'h00, 8'h00, 1'b0);  // R8 most positive
    run_op(4'd15, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0);  // R1 unused code as implied
    run_op(4'd1, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0);   // R2 accumulator
    run_op(4'd2, 8'h12, 8'h34, 8'h00, 8'h00, 1'b0);   // R2 immediate
    run_op(4'd9, 8'h10, 8'h20, 8'h05, 8'h00, 1'b1);   // R9 start ignored while busy
    run_op(4'd3, 8'h44, 8'h20, 8'h05, 8'h00, 1'b1);   // R9 start ignored in done cycle

    for (int i = 0; i < 300; i++) begin
      run_op(4'($urandom % 16), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             1'($urandom % 4 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule